// File: doc/BRIEF.md
# Command Issue and Stall Controller

This block sits at the front of a vector-interface command processor. It takes 32-bit command words from a first-word-fall-through FIFO and fetches them one per cycle. Each word goes into a readable last-code register, and the block then decodes it. A two-bit issue state (idle, wait, decode, stall) is kept in a status word. When a command finishes, the block hands it to the execution side as a one-cycle pulse that carries the command word.

Three events can stop issue. An illegal opcode raises an illegal-code flag. A DMA tag word found where an operand word was expected raises a tag-mismatch flag. A command with its interrupt bit set raises an interrupt-stall flag. Each of these flags is latched only when its bit in the error-mask register is clear. A command with the interrupt bit stalls once before it executes; a loop-prevention flag lets it run when issue resumes. The mark command is the exception and executes at once. A small host port reads the status, mask, mark and last-code registers, and it can issue a full soft reset or a stall-cancel.

Top module: `cmd_issue_ctrl`

## Requirements
- R1: After the synchronous reset, and after a control write (address 1) with bit 0 set, the status word, last-code, mark and mask registers all read zero.
- R2: Command word fields are: bit 31 interrupt, bits 30:24 opcode, bits 23:16 count, bits 15:0 immediate. Each command word fetched for decode is stored in the last-code register (address 4). A word flagged as DMA tag in the command position is dropped and not stored.
- R3: Opcode 0x00 is a no-op. Opcode 0x07 loads the immediate, zero-extended, into the mark register (address 3). Opcode 0x30 consumes count further operand words. Every completed command gives exactly one exec_valid pulse carrying its word.
- R4: The status word (address 0) holds the state in bits 1:0, encoded idle 0, wait 1, decode 2, stall 3. It holds the illegal-code flag at bit 13, tag-mismatch at bit 12, interrupt seen at bit 11 and interrupt-stall at bit 10. The state is wait while operands are still owed and the FIFO is empty.
- R5: While the tag-mismatch, illegal-code or interrupt-stall flag is set, no command word is consumed and the state is stall.
- R6: An illegal opcode is consumed. If mask bit 2 is clear, it sets the illegal-code flag and the state becomes stall. If mask bit 2 is set, no flag is raised, the state returns to idle and the next command executes.
- R7: A new interrupt-flagged command that is not mark sets the interrupt-seen flag. It also sets interrupt-stall if mask bit 0 is clear. It then enters stall without executing and without being consumed.
- R8: When issue resumes after such a stall, the same command executes once and does not raise interrupt-seen again. With mask bit 0 set, it executes after a single stall cycle.
- R9: A mark command with the interrupt bit set executes immediately and still sets interrupt-seen and interrupt-stall.
- R10: A tag word in an operand position is skipped and not counted. If mask bit 1 is clear, it sets tag-mismatch. The command still completes, and the stall appears at the next issue.
- R11: A control write with bit 3 set clears all four flags and moves the stall state to idle. Any control write holds issue for that cycle. Read data is registered and returned one cycle after the read request.
- R12: The mask register (address 2, 4 bits) reads back its written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | FIFO head word present |
| in_word | input | 32 | FIFO head word |
| in_is_tag | input | 1 | Head word is a DMA tag |
| in_pop | output | 1 | Consume head word this cycle |
| host_valid | input | 1 | Host access strobe |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register address |
| host_wdata | input | 4 | Write data |
| host_rdata | output | 32 | Registered read data |
| exec_valid | output | 1 | One-cycle pulse when a command completes |
| exec_word | output | 32 | Word of the completed command |

## Verification
The collision that matters is a host stall-cancel write in the same cycle as a stalled interrupt-flagged command waiting at the FIFO head. The bench drives the cancel while that word is present. It checks that in_pop stays low during the cancel cycle, that no execute pulse follows that edge, and that the command executes on the very next edge without stalling again. A second overlap is a mask write in the same cycle as a flag-raising issue; the rule is that the issue uses the old mask.

// File: rtl/cis_pkg.sv
package cis_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_DECODE = 2'd2,
    ST_STALL  = 2'd3
  } iss_state_e;

  typedef enum logic [1:0] {
    K_NOP  = 2'd0,
    K_MARK = 2'd1,
    K_LOAD = 2'd2,
    K_BAD  = 2'd3
  } cmd_kind_e;

  localparam logic [6:0] OPC_NOP  = 7'h00;
  localparam logic [6:0] OPC_MARK = 7'h07;
  localparam logic [6:0] OPC_LOAD = 7'h30;

  localparam int BIT_INTR = 31;
  localparam int BIT_ILL  = 13;
  localparam int BIT_TAGE = 12;
  localparam int BIT_INTS = 11;
  localparam int BIT_ISTL = 10;

  localparam int MSK_INT  = 0;
  localparam int MSK_TAG  = 1;
  localparam int MSK_ILL  = 2;

  localparam logic [2:0] RA_STATUS = 3'd0;
  localparam logic [2:0] RA_CTRL   = 3'd1;
  localparam logic [2:0] RA_MASK   = 3'd2;
  localparam logic [2:0] RA_MARK   = 3'd3;
  localparam logic [2:0] RA_CODE   = 3'd4;
endpackage

// File: rtl/cis_decode.sv
module cis_decode
  import cis_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 8,
  parameter int IMM_W  = 16
) (
  input  logic [WORD_W-1:0] word,
  output logic              intr,
  output cmd_kind_e         kind,
  output logic [CNT_W-1:0]  count,
  output logic [IMM_W-1:0]  imm
);
  localparam int OPC_LO = IMM_W + CNT_W;

  logic [6:0] opc;

  always_comb begin
    intr  = word[WORD_W-1];
    opc   = word[WORD_W-2:OPC_LO];
    count = word[OPC_LO-1:IMM_W];
    imm   = word[IMM_W-1:0];
    unique case (opc)
      OPC_NOP:  kind = K_NOP;
      OPC_MARK: kind = K_MARK;
      OPC_LOAD: kind = K_LOAD;
      default:  kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/cis_host_regs.sv
module cis_host_regs
  import cis_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 3,
  parameter int HW_W   = 4,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [HW_W-1:0]   host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic [WORD_W-1:0] status_in,
  input  logic [WORD_W-1:0] code_in,
  input  logic [IMM_W-1:0]  mark_in,
  output logic [HW_W-1:0]   mask_o,
  output logic              soft_rst,
  output logic              cancel,
  output logic              ctl_hold
);
  logic wr_ctrl, wr_mask, rd_req;

  always_comb begin
    wr_ctrl  = host_valid && host_write && (host_addr == ADDR_W'(RA_CTRL));
    wr_mask  = host_valid && host_write && (host_addr == ADDR_W'(RA_MASK));
    rd_req   = host_valid && !host_write;
    soft_rst = wr_ctrl && host_wdata[0];
    cancel   = wr_ctrl && host_wdata[3];
    ctl_hold = wr_ctrl;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      mask_o <= '0;
    end else if (wr_mask) begin
      mask_o <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (rd_req) begin
      unique case (host_addr)
        ADDR_W'(RA_STATUS): host_rdata <= status_in;
        ADDR_W'(RA_MASK):   host_rdata <= WORD_W'(mask_o);
        ADDR_W'(RA_MARK):   host_rdata <= WORD_W'(mark_in);
        ADDR_W'(RA_CODE):   host_rdata <= code_in;
        default:            host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cis_issue.sv
module cis_issue
  import cis_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 8,
  parameter int IMM_W  = 16,
  parameter int HW_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              cancel,
  input  logic              ctl_hold,
  input  logic [HW_W-1:0]   mask,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_is_tag,
  output logic              in_pop,
  output logic [WORD_W-1:0] status_o,
  output logic [WORD_W-1:0] code_o,
  output logic [IMM_W-1:0]  mark_o,
  output logic              exec_valid,
  output logic [WORD_W-1:0] exec_word,
  output logic              opnd_busy
);
  iss_state_e       st_q, st_n;
  logic             ill_q, ill_n, tage_q, tage_n, ints_q, ints_n, istl_q, istl_n;
  logic             noloop_q, noloop_n;
  logic [CNT_W-1:0] rem_q, rem_n;
  logic [WORD_W-1:0] code_n;
  logic [IMM_W-1:0] mark_n;
  logic             exv_n;
  logic [WORD_W-1:0] exw_n;

  logic             d_intr;
  cmd_kind_e        d_kind;
  logic [CNT_W-1:0] d_count;
  logic [IMM_W-1:0] d_imm;

  cis_decode #(.WORD_W(WORD_W), .CNT_W(CNT_W), .IMM_W(IMM_W)) u_dec (
    .word (in_word),
    .intr (d_intr),
    .kind (d_kind),
    .count(d_count),
    .imm  (d_imm)
  );

  logic flags_any;
  assign flags_any = ill_q || tage_q || istl_q;
  assign opnd_busy = (rem_q != '0);

  always_comb begin
    st_n = st_q;  ill_n = ill_q;  tage_n = tage_q;  ints_n = ints_q;
    istl_n = istl_q;  noloop_n = noloop_q;  rem_n = rem_q;
    code_n = code_o;  mark_n = mark_o;  exv_n = 1'b0;  exw_n = exec_word;
    in_pop = 1'b0;
    if (soft_rst) begin
      st_n = ST_IDLE;  ill_n = 1'b0;  tage_n = 1'b0;  ints_n = 1'b0;
      istl_n = 1'b0;  noloop_n = 1'b0;  rem_n = '0;
      code_n = '0;  mark_n = '0;
    end else if (cancel) begin
      ill_n = 1'b0;  tage_n = 1'b0;  ints_n = 1'b0;  istl_n = 1'b0;
      if (st_q == ST_STALL) st_n = ST_IDLE;
    end else if (ctl_hold) begin
      st_n = st_q;
    end else if (opnd_busy) begin
      if (!in_valid) begin
        st_n = ST_WAIT;
      end else begin
        in_pop = 1'b1;
        if (in_is_tag) begin
          if (!mask[MSK_TAG]) tage_n = 1'b1;
        end else if (rem_q == CNT_W'(1)) begin
          rem_n = '0;  st_n = ST_IDLE;  exv_n = 1'b1;  exw_n = code_o;
        end else begin
          rem_n = rem_q - CNT_W'(1);  st_n = ST_DECODE;
        end
      end
    end else if (!in_valid) begin
      st_n = st_q;
    end else if (in_is_tag) begin
      in_pop = 1'b1;
    end else if (flags_any) begin
      st_n = ST_STALL;
    end else begin
      code_n = in_word;
      if (d_intr && !noloop_q && (d_kind != K_MARK)) begin
        ints_n = 1'b1;  noloop_n = 1'b1;  st_n = ST_STALL;
        if (!mask[MSK_INT]) istl_n = 1'b1;
      end else begin
        if (d_intr && !noloop_q) begin
          ints_n = 1'b1;
          if (!mask[MSK_INT]) istl_n = 1'b1;
        end
        noloop_n = 1'b0;
        in_pop   = 1'b1;
        unique case (d_kind)
          K_NOP: begin
            st_n = ST_IDLE;  exv_n = 1'b1;  exw_n = in_word;
          end
          K_MARK: begin
            mark_n = d_imm;  st_n = ST_IDLE;  exv_n = 1'b1;  exw_n = in_word;
          end
          K_LOAD: begin
            if (d_count == '0) begin
              st_n = ST_IDLE;  exv_n = 1'b1;  exw_n = in_word;
            end else begin
              rem_n = d_count;  st_n = ST_DECODE;
            end
          end
          default: begin
            if (!mask[MSK_ILL]) begin
              ill_n = 1'b1;  st_n = ST_STALL;
            end else begin
              st_n = ST_IDLE;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;  ill_q <= 1'b0;  tage_q <= 1'b0;  ints_q <= 1'b0;
      istl_q <= 1'b0;  noloop_q <= 1'b0;  rem_q <= '0;
      code_o <= '0;  mark_o <= '0;  exec_valid <= 1'b0;  exec_word <= '0;
    end else begin
      st_q <= st_n;  ill_q <= ill_n;  tage_q <= tage_n;  ints_q <= ints_n;
      istl_q <= istl_n;  noloop_q <= noloop_n;  rem_q <= rem_n;
      code_o <= code_n;  mark_o <= mark_n;  exec_valid <= exv_n;  exec_word <= exw_n;
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[1:0]      = st_q;
    status_o[BIT_ILL]  = ill_q;
    status_o[BIT_TAGE] = tage_q;
    status_o[BIT_INTS] = ints_q;
    status_o[BIT_ISTL] = istl_q;
  end
endmodule

// File: rtl/cmd_issue_ctrl.sv
module cmd_issue_ctrl
  import cis_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 3,
  parameter int HW_W   = 4,
  parameter int CNT_W  = 8,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_is_tag,
  output logic              in_pop,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [HW_W-1:0]   host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              exec_valid,
  output logic [WORD_W-1:0] exec_word
);
  logic [WORD_W-1:0] status_w, code_w;
  logic [IMM_W-1:0]  mark_w;
  logic [HW_W-1:0]   mask_w;
  logic              soft_rst_w, cancel_w, hold_w, busy_w;

  cis_host_regs #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .HW_W(HW_W), .IMM_W(IMM_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .host_valid(host_valid),
    .host_write(host_write),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .status_in (status_w),
    .code_in   (code_w),
    .mark_in   (mark_w),
    .mask_o    (mask_w),
    .soft_rst  (soft_rst_w),
    .cancel    (cancel_w),
    .ctl_hold  (hold_w)
  );

  cis_issue #(.WORD_W(WORD_W), .CNT_W(CNT_W), .IMM_W(IMM_W), .HW_W(HW_W)) u_iss (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst_w),
    .cancel    (cancel_w),
    .ctl_hold  (hold_w),
    .mask      (mask_w),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .in_is_tag (in_is_tag),
    .in_pop    (in_pop),
    .status_o  (status_w),
    .code_o    (code_w),
    .mark_o    (mark_w),
    .exec_valid(exec_valid),
    .exec_word (exec_word),
    .opnd_busy (busy_w)
  );
endmodule

// File: rtl/cis_checker.sv
module cis_checker #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 3,
  parameter int HW_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_pop,
  input logic              in_is_tag,
  input logic              host_valid,
  input logic              host_write,
  input logic [ADDR_W-1:0] host_addr,
  input logic [HW_W-1:0]   host_wdata,
  input logic [WORD_W-1:0] status_w,
  input logic [HW_W-1:0]   mask_w,
  input logic              busy_w
);
  logic stall_flags;
  assign stall_flags = status_w[13] || status_w[12] || status_w[10];

  // R5: stalled controller never consumes a command word
  a_r5_no_pop_when_stalled: assert property (@(posedge clk) disable iff (rst)
    (stall_flags && !busy_w && !in_is_tag) |-> !in_pop);

  // R6: illegal-code flag only rises with its mask clear
  a_r6_ill_masked: assert property (@(posedge clk) disable iff (rst)
    $rose(status_w[13]) |-> !$past(mask_w[2]));

  // R7: interrupt-stall only rises with its mask clear, together with interrupt-seen
  a_r7_istl_masked: assert property (@(posedge clk) disable iff (rst)
    $rose(status_w[10]) |-> (!$past(mask_w[0]) && status_w[11]));

  // R10: tag-mismatch only rises with its mask clear
  a_r10_tag_masked: assert property (@(posedge clk) disable iff (rst)
    $rose(status_w[12]) |-> !$past(mask_w[1]));

  // R11: a cancel write leaves every flag clear and the state out of stall
  a_r11_cancel_clears: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_write && host_addr == ADDR_W'(1) && host_wdata[3])
      |=> (status_w[13:10] == 4'b0 && status_w[1:0] != 2'd3));
endmodule

bind cmd_issue_ctrl cis_checker #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .HW_W(HW_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_pop    (in_pop),
  .in_is_tag (in_is_tag),
  .host_valid(host_valid),
  .host_write(host_write),
  .host_addr (host_addr),
  .host_wdata(host_wdata),
  .status_w  (status_w),
  .mask_w    (mask_w),
  .busy_w    (busy_w)
);

// File: tb/cmd_issue_ctrl_bench.sv
module cmd_issue_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid, in_is_tag, in_pop;
  logic [31:0] in_word;
  logic        host_valid = 1'b0, host_write = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [3:0]  host_wdata = '0;
  logic [31:0] host_rdata, exec_word;
  logic        exec_valid;

  int n_tests = 0;
  int n_fail  = 0;
  int exec_cnt = 0;
  int cycles = 0;
  logic [32:0] fmem [0:255];
  int wr = 0;
  int rd = 0;

  always #5 clk = ~clk;

  cmd_issue_ctrl u_cmd_issue_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .in_is_tag(in_is_tag), .in_pop(in_pop), .host_valid(host_valid),
    .host_write(host_write), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .exec_valid(exec_valid), .exec_word(exec_word)
  );

  assign in_valid  = (rd < wr);
  assign in_word   = fmem[rd[7:0]][31:0];
  assign in_is_tag = fmem[rd[7:0]][32];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) rd <= 0;
    else if (in_pop) rd <= rd + 1;
    if (!rst && exec_valid) exec_cnt <= exec_cnt + 1;
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic tag, input logic [31:0] w);
    @(negedge clk);
    fmem[wr[7:0]] = {tag, w};
    wr = wr + 1;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_valid = 1'b0; host_write = 1'b0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b0; host_addr = a;
    @(posedge clk); #1;
    host_valid = 1'b0;
    v = host_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr = 0;
    settle(2);
    @(negedge clk);
    rst = 1'b0;
    exec_cnt = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    hread(3'd0, v); check("R1 status after reset", v, 32'h0);
    hread(3'd4, v); check("R1 code after reset", v, 32'h0);
    hread(3'd3, v); check("R1 mark after reset", v, 32'h0);
    hread(3'd2, v); check("R1 mask after reset", v, 32'h0);
  endtask

  task automatic t_nop_mark();
    logic [31:0] v;
    int e0;
    do_reset();
    e0 = exec_cnt;
    push(1'b0, 32'h0000_0000);
    push(1'b0, 32'h0700_1234);
    settle(6);
    hread(3'd3, v); check("R3 mark loads immediate", v, 32'h1234);
    hread(3'd4, v); check("R2 code holds last word", v, 32'h0700_1234);
    hread(3'd0, v); check("R4 idle after commands", v, 32'h0);
    check("R3 two exec pulses", 32'(exec_cnt - e0), 32'd2);
  endtask

  task automatic t_illegal();
    logic [31:0] v;
    do_reset();
    push(1'b0, 32'h0800_0000);
    push(1'b0, 32'h0700_00BB);
    settle(6);
    hread(3'd0, v); check("R6 illegal sets flag and stall", v, 32'h0000_2003);
    hread(3'd4, v); check("R2 code holds bad word", v, 32'h0800_0000);
    hread(3'd3, v); check("R5 following mark blocked", v, 32'h0);
    hwrite(3'd1, 4'h8);
    settle(4);
    hread(3'd3, v); check("R11 cancel resumes issue", v, 32'hBB);
    hread(3'd0, v); check("R11 flags cleared", v, 32'h0);
  endtask

  task automatic t_illegal_masked();
    logic [31:0] v;
    do_reset();
    hwrite(3'd2, 4'h4);
    push(1'b0, 32'h0800_0000);
    push(1'b0, 32'h0700_0022);
    settle(6);
    hread(3'd0, v); check("R6 masked illegal, no flag", v, 32'h0);
    hread(3'd3, v); check("R6 next command runs", v, 32'h22);
    hread(3'd2, v); check("R12 mask readback", v, 32'h4);
  endtask

  task automatic t_intr();
    logic [31:0] v;
    do_reset();
    push(1'b0, 32'h8000_0000);
    push(1'b0, 32'h0700_00CC);
    settle(6);
    hread(3'd0, v); check("R7 interrupt stall status", v, 32'h0000_0C03);
    hread(3'd4, v); check("R2 code holds interrupt word", v, 32'h8000_0000);
    check("R7 nothing executed", 32'(exec_cnt), 32'd0);
    hwrite(3'd1, 4'h8);
    settle(6);
    hread(3'd3, v); check("R8 mark after resume", v, 32'hCC);
    hread(3'd0, v); check("R8 no second interrupt", v, 32'h0);
    check("R8 two exec pulses", 32'(exec_cnt), 32'd2);
  endtask

  task automatic t_intr_masked();
    logic [31:0] v;
    do_reset();
    hwrite(3'd2, 4'h1);
    push(1'b0, 32'h8000_0000);
    push(1'b0, 32'h0700_00DD);
    settle(8);
    hread(3'd0, v); check("R8 masked: INT only, idle", v, 32'h0000_0800);
    hread(3'd3, v); check("R8 masked: mark ran", v, 32'hDD);
    check("R8 masked: two exec", 32'(exec_cnt), 32'd2);
  endtask

  task automatic t_intr_mark();
    logic [31:0] v;
    do_reset();
    push(1'b0, 32'h8700_00EE);
    push(1'b0, 32'h0700_0011);
    settle(6);
    hread(3'd3, v); check("R9 mark runs at once", v, 32'hEE);
    hread(3'd0, v); check("R9 INT and PIS, stalled", v, 32'h0000_0C03);
    hread(3'd4, v); check("R9 code is mark word", v, 32'h8700_00EE);
  endtask

  task automatic t_operands();
    logic [31:0] v;
    do_reset();
    push(1'b0, 32'h3003_0000);
    push(1'b0, 32'h1111_1111);
    settle(4);
    hread(3'd0, v); check("R4 wait state while operands owed", v, 32'h1);
    push(1'b1, 32'hAAAA_AAAA);
    push(1'b0, 32'h2222_2222);
    push(1'b0, 32'h3333_3333);
    push(1'b0, 32'h0700_0055);
    settle(6);
    hread(3'd0, v); check("R10 tag mismatch then stall", v, 32'h0000_1003);
    check("R10 command completed", 32'(exec_cnt), 32'd1);
    hread(3'd3, v); check("R10 mark blocked", v, 32'h0);
    hread(3'd4, v); check("R10 code unchanged", v, 32'h3003_0000);
  endtask

  task automatic t_operands_masked();
    logic [31:0] v;
    do_reset();
    hwrite(3'd2, 4'h2);
    push(1'b0, 32'h3002_0000);
    push(1'b1, 32'hAAAA_AAAA);
    push(1'b0, 32'h1);
    push(1'b0, 32'h2);
    push(1'b0, 32'h0700_0033);
    settle(8);
    hread(3'd0, v); check("R10 masked tag, no flag", v, 32'h0);
    hread(3'd3, v); check("R10 masked, mark ran", v, 32'h33);
  endtask

  task automatic t_soft_reset();
    logic [31:0] v;
    do_reset();
    hwrite(3'd2, 4'h1);
    push(1'b0, 32'h0700_0077);
    push(1'b0, 32'h0900_0000);
    settle(6);
    hread(3'd0, v); check("R6 flag before soft reset", v, 32'h0000_2003);
    hwrite(3'd1, 4'h1);
    hread(3'd0, v); check("R1 soft reset status", v, 32'h0);
    hread(3'd2, v); check("R1 soft reset mask", v, 32'h0);
    hread(3'd3, v); check("R1 soft reset mark", v, 32'h0);
    hread(3'd4, v); check("R1 soft reset code", v, 32'h0);
  endtask

  task automatic t_tag_head();
    logic [31:0] v;
    do_reset();
    push(1'b1, 32'h0700_0099);
    push(1'b0, 32'h0700_0044);
    settle(6);
    hread(3'd3, v); check("R2 tag at head dropped", v, 32'h44);
    hread(3'd4, v); check("R2 tag not stored", v, 32'h0700_0044);
    check("R2 one exec", 32'(exec_cnt), 32'd1);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    do_reset();
    push(1'b0, 32'h8000_0000);
    settle(5);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_addr = 3'd1; host_wdata = 4'h8;
    #1;
    check("R11 no pop during cancel", 32'(in_pop), 32'd0);
    @(posedge clk); #1;
    host_valid = 1'b0; host_write = 1'b0;
    check("R11 no exec on cancel edge", 32'(exec_valid), 32'd0);
    @(posedge clk); #1;
    check("R8 resumed command executes next edge", 32'(exec_valid), 32'd1);
    check("R3 exec word", exec_word, 32'h8000_0000);
    settle(2);
    hread(3'd0, v); check("R8 no re-stall after resume", v, 32'h0);
  endtask

  initial begin
    in_word_init();
    t_reset();
    t_nop_mark();
    t_illegal();
    t_illegal_masked();
    t_intr();
    t_intr_masked();
    t_intr_mark();
    t_operands();
    t_operands_masked();
    t_soft_reset();
    t_tag_head();
    t_collision();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic in_word_init();
    for (int i = 0; i < 256; i++) fmem[i] = '0;
  endtask
endmodule